// File: doc/BRIEF.md
# Sleep and Resume Power Sequencer

This block moves a system between full-on operation and three sleep states: suspend-to-RAM, suspend-to-disk and soft-off. Software starts a sleep by presenting a 3-bit sleep-type code together with a one-cycle write-one enable strobe. The sequencer then raises the processor stop-clock request and waits for the stop-grant acknowledge. After that it drives the cache sleep output, then the clock-stop output, and finally drops the power-on output. An enabled resume event brings the system back by running the same outputs in reverse order. The block sets a wake status bit on the way and records which sleep state the system returned from.

There are two forced paths into soft-off: a full-reset command issued in full-on, and a power button held for a programmable number of slow ticks. Both skip the stop-clock request and the acknowledge wait. They assert the clock-stop output first and then remove power. Every delay is counted in cycles of the block clock (the PCI clock).

Top module: `slp_sequencer`

## Requirements
- R1: After reset, stop-clock, cache sleep and clock-stop are low, power-on is high, the block is not asleep, wake status is 0 and the previous-state field is 0.
- R2: In full-on, a sleep-enable strobe with sleep type 5 (suspend-to-RAM), 6 (suspend-to-disk) or 7 (soft-off) raises stop-clock on the next cycle. A strobe carrying any other code leaves the block in full-on with every output unchanged.
- R3: On a normal entry, the sequencer holds stop-clock high and waits for stop-grant acknowledge. Cache sleep rises on the cycle after the acknowledge is seen, clock-stop rises STEP_DLY cycles later, and power-on falls STEP_DLY cycles after that, at which point the block reports asleep.
- R4: A sleep-enable strobe outside full-on is ignored and does not change the target state. A resume event outside the asleep state is ignored.
- R5: A resume event while asleep sets wake status. A wake-clear strobe clears it, and a set in the same cycle wins over the clear.
- R6: On resume, power-on rises on the next cycle. Clock-stop falls STEP_DLY cycles later. Cache sleep falls WAKE_DLY cycles after that, which is at least 4 cycles after the resume event. Stop-clock falls STPCLK_DLY cycles later, together with the return to full-on.
- R7: On the return to full-on, the previous-state field takes the sleep type of the state just left.
- R8: A full-reset command in full-on raises clock-stop on the next cycle, with stop-clock and cache sleep staying low. Power-on falls STEP_DLY cycles later, and the target becomes soft-off (7).
- R9: When the power button stays pressed for HOLD_TICKS slow ticks in any state other than soft-off sleep, the sequencer takes the same path as R8. If this happens during suspend-to-RAM or suspend-to-disk sleep, the target changes to soft-off without leaving sleep. In soft-off sleep the hold has no effect.
- R10: Releasing the power button clears the hold count, so a later press must again last HOLD_TICKS full ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (PCI clock) |
| rstN | input | 1 | Asynchronous active-low reset |
| slpType | input | 3 | Sleep-type code written with the enable strobe |
| slpEnWr | input | 1 | One-cycle write-one sleep-enable strobe |
| resumeEvt | input | 1 | Enabled resume event |
| wakeClr | input | 1 | Write-one clear of the wake status |
| fullRstCmd | input | 1 | Full-reset command strobe |
| stopGntAck | input | 1 | Processor stop-grant acknowledge |
| pwrBtn | input | 1 | Power button pressed (active high) |
| secTick | input | 1 | Slow tick used to time the button hold |
| stpClkReq | output | 1 | Processor stop-clock request |
| cacheSleep | output | 1 | Cache sleep output |
| clkStop | output | 1 | Clock-stop output |
| pwrOn | output | 1 | Power-on output |
| asleep | output | 1 | System is in a sleep state |
| wakeSts | output | 1 | Wake status bit |
| prevState | output | 3 | Sleep type most recently returned from |

## Verification
Some ordering rules are checked on every cycle by the embedded properties. Stop-clock may only rise after a sleep-enable strobe. Clock-stop rises either after both stop-clock and cache sleep or with neither of them. Cache sleep drops while stop-clock is still high. Power drops only after clock-stop has been high for a full cycle. The hold count is empty after a release, and wake status only rises on a taken resume. Exact cycle counts cannot be shown by those properties and come only from the bench's reference model in its scenarios: the acknowledge wait, the at-least-four-cycle gap before cache sleep falls, the ignored strobes, the override from sleep, and the previous-state capture.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;

  localparam logic [2:0] TYP_STR  = 3'd5;
  localparam logic [2:0] TYP_STD  = 3'd6;
  localparam logic [2:0] TYP_SOFF = 3'd7;

  typedef enum logic [3:0] {
    ST_ON     = 4'd0,
    ST_WAIT   = 4'd1,
    ST_CACHE  = 4'd2,
    ST_CSTOP  = 4'd3,
    ST_SLEEP  = 4'd4,
    ST_RPWR   = 4'd5,
    ST_RRUN   = 4'd6,
    ST_RSTP   = 4'd7,
    ST_OVR    = 4'd8
  } seqState_e;

  typedef enum logic [1:0] {
    DLY_STEP   = 2'd0,
    DLY_WAKE   = 2'd1,
    DLY_STPCLK = 2'd2
  } dlySel_e;

  typedef struct packed {
    logic    loadDly;
    dlySel_e dlySel;
    logic    latchType;
    logic    forceSoff;
    logic    setWake;
    logic    savePrev;
  } seqStrobe_t;

endpackage

// File: rtl/slp_seq_dpath.sv
module slp_seq_dpath
  import slp_seq_pkg::*;
#(
  parameter int STEP_DLY   = 2,
  parameter int WAKE_DLY   = 4,
  parameter int STPCLK_DLY = 3,
  parameter int HOLD_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic [2:0] slpType,
  input  logic       wakeClr,
  input  logic       pwrBtn,
  input  logic       secTick,
  output logic       dlyDone,
  output logic       holdDone,
  output logic [2:0] curType,
  output logic       wakeSts,
  output logic [2:0] prevState
);

  localparam int MAX_A = (STEP_DLY > WAKE_DLY) ? STEP_DLY : WAKE_DLY;
  localparam int MAX_D = (MAX_A > STPCLK_DLY) ? MAX_A : STPCLK_DLY;
  localparam int DW    = $clog2(MAX_D + 1);
  localparam int HW    = $clog2(HOLD_TICKS + 1);

  logic [DW-1:0] dlyCnt;
  logic [DW-1:0] loadVal;
  logic [HW-1:0] holdCnt;

  always_comb begin
    unique case (strb.dlySel)
      DLY_WAKE:   loadVal = DW'(WAKE_DLY - 1);
      DLY_STPCLK: loadVal = DW'(STPCLK_DLY - 1);
      default:    loadVal = DW'(STEP_DLY - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (strb.loadDly) begin
      dlyCnt <= loadVal;
    end else if (dlyCnt != '0) begin
      dlyCnt <= dlyCnt - 1'b1;
    end
  end

  assign dlyDone = (dlyCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!pwrBtn) begin
      holdCnt <= '0;
    end else if (secTick && (holdCnt != HW'(HOLD_TICKS))) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdDone = pwrBtn && secTick && (holdCnt == HW'(HOLD_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curType <= '0;
    end else if (strb.forceSoff) begin
      curType <= TYP_SOFF;
    end else if (strb.latchType) begin
      curType <= slpType;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeSts <= 1'b0;
    end else if (strb.setWake) begin
      wakeSts <= 1'b1;
    end else if (wakeClr) begin
      wakeSts <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevState <= '0;
    end else if (strb.savePrev) begin
      prevState <= curType;
    end
  end

  // R10
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pwrBtn |=> (holdCnt == '0));

  // R5
  wake_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeSts) |-> $past(strb.setWake));

  // R7
  prev_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(prevState) |-> $past(strb.savePrev));

endmodule

// File: rtl/slp_seq_ctrl.sv
module slp_seq_ctrl
  import slp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] slpType,
  input  logic       slpEnWr,
  input  logic       resumeEvt,
  input  logic       fullRstCmd,
  input  logic       stopGntAck,
  input  logic       dlyDone,
  input  logic       holdDone,
  input  logic [2:0] curType,
  output seqStrobe_t strb,
  output logic       stpClkO,
  output logic       cacheSleepO,
  output logic       clkStopO,
  output logic       pwrOnO,
  output logic       asleepO
);

  seqState_e st, stN;
  logic      ovrFlag, ovrN;
  logic      validReq;

  assign validReq = slpEnWr &&
                    ((slpType == TYP_STR) || (slpType == TYP_STD) || (slpType == TYP_SOFF));

  always_comb begin
    stN     = st;
    ovrN    = ovrFlag;
    strb    = '0;
    if (st == ST_SLEEP) begin
      if (holdDone && (curType != TYP_SOFF)) begin
        strb.forceSoff = 1'b1;
      end else if (resumeEvt) begin
        stN          = ST_RPWR;
        strb.setWake = 1'b1;
        strb.loadDly = 1'b1;
        strb.dlySel  = DLY_STEP;
      end
    end else if (holdDone || ((st == ST_ON) && fullRstCmd)) begin
      stN            = ST_OVR;
      ovrN           = 1'b1;
      strb.forceSoff = 1'b1;
      strb.loadDly   = 1'b1;
      strb.dlySel    = DLY_STEP;
    end else begin
      unique case (st)
        ST_ON: begin
          if (validReq) begin
            stN            = ST_WAIT;
            ovrN           = 1'b0;
            strb.latchType = 1'b1;
          end
        end
        ST_WAIT: begin
          if (stopGntAck) begin
            stN          = ST_CACHE;
            strb.loadDly = 1'b1;
            strb.dlySel  = DLY_STEP;
          end
        end
        ST_CACHE: begin
          if (dlyDone) begin
            stN          = ST_CSTOP;
            strb.loadDly = 1'b1;
            strb.dlySel  = DLY_STEP;
          end
        end
        ST_CSTOP, ST_OVR: begin
          if (dlyDone) stN = ST_SLEEP;
        end
        ST_RPWR: begin
          if (dlyDone) begin
            stN          = ST_RRUN;
            strb.loadDly = 1'b1;
            strb.dlySel  = DLY_WAKE;
          end
        end
        ST_RRUN: begin
          if (dlyDone) begin
            stN          = ST_RSTP;
            strb.loadDly = 1'b1;
            strb.dlySel  = DLY_STPCLK;
          end
        end
        ST_RSTP: begin
          if (dlyDone) begin
            stN           = ST_ON;
            ovrN          = 1'b0;
            strb.savePrev = 1'b1;
          end
        end
        default: stN = ST_ON;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_ON;
      ovrFlag <= 1'b0;
    end else begin
      st      <= stN;
      ovrFlag <= ovrN;
    end
  end

  always_comb begin
    stpClkO     = 1'b0;
    cacheSleepO = 1'b0;
    clkStopO    = 1'b0;
    pwrOnO      = 1'b1;
    asleepO     = 1'b0;
    unique case (st)
      ST_WAIT:  stpClkO = 1'b1;
      ST_CACHE: begin stpClkO = 1'b1; cacheSleepO = 1'b1; end
      ST_CSTOP: begin stpClkO = 1'b1; cacheSleepO = 1'b1; clkStopO = 1'b1; end
      ST_SLEEP: begin
        stpClkO = !ovrFlag; cacheSleepO = !ovrFlag; clkStopO = 1'b1;
        pwrOnO  = 1'b0;     asleepO     = 1'b1;
      end
      ST_RPWR:  begin stpClkO = !ovrFlag; cacheSleepO = !ovrFlag; clkStopO = 1'b1; end
      ST_RRUN:  begin stpClkO = !ovrFlag; cacheSleepO = !ovrFlag; end
      ST_RSTP:  stpClkO = !ovrFlag;
      ST_OVR:   clkStopO = 1'b1;
      default:  ;
    endcase
  end

  // R2
  stpclk_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stpClkO) |-> $past(slpEnWr));

  // R3
  clkstop_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStopO) |-> (stpClkO == cacheSleepO));

  // R6
  cache_before_stpclk_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cacheSleepO) |-> stpClkO);

  // R8
  pwr_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrOnO) |-> (clkStopO && $past(clkStopO)));

endmodule

// File: rtl/slp_sequencer.sv
module slp_sequencer
  import slp_seq_pkg::*;
#(
  parameter int STEP_DLY   = 2,
  parameter int WAKE_DLY   = 4,
  parameter int STPCLK_DLY = 3,
  parameter int HOLD_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] slpType,
  input  logic       slpEnWr,
  input  logic       resumeEvt,
  input  logic       wakeClr,
  input  logic       fullRstCmd,
  input  logic       stopGntAck,
  input  logic       pwrBtn,
  input  logic       secTick,
  output logic       stpClkReq,
  output logic       cacheSleep,
  output logic       clkStop,
  output logic       pwrOn,
  output logic       asleep,
  output logic       wakeSts,
  output logic [2:0] prevState
);

  seqStrobe_t strb;
  logic       dlyDone;
  logic       holdDone;
  logic [2:0] curType;

  slp_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .slpType     (slpType),
    .slpEnWr     (slpEnWr),
    .resumeEvt   (resumeEvt),
    .fullRstCmd  (fullRstCmd),
    .stopGntAck  (stopGntAck),
    .dlyDone     (dlyDone),
    .holdDone    (holdDone),
    .curType     (curType),
    .strb        (strb),
    .stpClkO     (stpClkReq),
    .cacheSleepO (cacheSleep),
    .clkStopO    (clkStop),
    .pwrOnO      (pwrOn),
    .asleepO     (asleep)
  );

  slp_seq_dpath #(
    .STEP_DLY   (STEP_DLY),
    .WAKE_DLY   (WAKE_DLY),
    .STPCLK_DLY (STPCLK_DLY),
    .HOLD_TICKS (HOLD_TICKS)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .slpType   (slpType),
    .wakeClr   (wakeClr),
    .pwrBtn    (pwrBtn),
    .secTick   (secTick),
    .dlyDone   (dlyDone),
    .holdDone  (holdDone),
    .curType   (curType),
    .wakeSts   (wakeSts),
    .prevState (prevState)
  );

endmodule

// File: tb/sim_slp_sequencer.sv
module sim_slp_sequencer;

  localparam int STEP   = 2;
  localparam int WAKE   = 4;
  localparam int STPCLK = 3;
  localparam int HOLD   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] slpType = 3'd0;
  logic slpEnWr = 1'b0, resumeEvt = 1'b0, wakeClr = 1'b0, fullRstCmd = 1'b0;
  logic stopGntAck = 1'b0, pwrBtn = 1'b0, secTick = 1'b0;
  logic stpClkReq, cacheSleep, clkStop, pwrOn, asleep, wakeSts;
  logic [2:0] prevState;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  slp_sequencer #(.STEP_DLY(STEP), .WAKE_DLY(WAKE), .STPCLK_DLY(STPCLK), .HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rstN(rstN), .slpType(slpType), .slpEnWr(slpEnWr), .resumeEvt(resumeEvt),
    .wakeClr(wakeClr), .fullRstCmd(fullRstCmd), .stopGntAck(stopGntAck), .pwrBtn(pwrBtn),
    .secTick(secTick), .stpClkReq(stpClkReq), .cacheSleep(cacheSleep), .clkStop(clkStop),
    .pwrOn(pwrOn), .asleep(asleep), .wakeSts(wakeSts), .prevState(prevState)
  );

  // Behavioural reference: phase 0 on, 1 wait ack, 2 cache, 3 clock stop, 4 asleep,
  // 5 power back, 6 clocks running, 7 release stop-clock, 8 forced soft-off.
  int ph = 0, left = 0, tgt = 0, prv = 0, hold = 0;
  bit ovr = 0, wk = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      ph = 0; left = 0; tgt = 0; prv = 0; hold = 0; ovr = 0; wk = 0;
    end else begin
      bit fire, setW;
      int nph;
      fire = pwrBtn && secTick && (hold == HOLD - 1);
      setW = 0;
      if (!pwrBtn) hold = 0;
      else if (secTick && hold < HOLD) hold++;
      nph = ph;
      if (ph == 4) begin
        if (fire && tgt != 7) tgt = 7;
        else if (resumeEvt) begin setW = 1; nph = 5; left = STEP - 1; end
      end else if (fire || (ph == 0 && fullRstCmd)) begin
        nph = 8; left = STEP - 1; tgt = 7; ovr = 1;
      end else begin
        case (ph)
          0: if (slpEnWr && slpType >= 5) begin nph = 1; tgt = slpType; ovr = 0; end
          1: if (stopGntAck) begin nph = 2; left = STEP - 1; end
          2: if (left == 0) begin nph = 3; left = STEP - 1; end else left--;
          3, 8: if (left == 0) nph = 4; else left--;
          5: if (left == 0) begin nph = 6; left = WAKE - 1; end else left--;
          6: if (left == 0) begin nph = 7; left = STPCLK - 1; end else left--;
          7: if (left == 0) begin nph = 0; prv = tgt; ovr = 0; end else left--;
          default: ;
        endcase
      end
      if (setW) wk = 1; else if (wakeClr) wk = 0;
      ph = nph;
    end
  end

  function automatic string tagOf(int p);
    case (p)
      0: return "R2";
      1, 2, 3: return "R3";
      8: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      int eStp, eCache, eCs, ePwr;
      eStp   = (ph >= 1 && ph <= 3) ? 1 : ((ph >= 4 && ph <= 7) ? int'(!ovr) : 0);
      eCache = (ph == 2 || ph == 3) ? 1 : ((ph >= 4 && ph <= 6) ? int'(!ovr) : 0);
      eCs    = (ph == 3 || ph == 4 || ph == 5 || ph == 8) ? 1 : 0;
      ePwr   = (ph == 4) ? 0 : 1;
      check(tagOf(ph), "stpClkReq", int'(stpClkReq), eStp);
      check(tagOf(ph), "cacheSleep", int'(cacheSleep), eCache);
      check(tagOf(ph), "clkStop", int'(clkStop), eCs);
      check(tagOf(ph), "pwrOn", int'(pwrOn), ePwr);
      check("R9", "asleep", int'(asleep), (ph == 4) ? 1 : 0);
      check("R5", "wakeSts", int'(wakeSts), int'(wk));
      check("R7", "prevState", int'(prevState), prv);
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic reqSleep(logic [2:0] t);
    slpType = t; slpEnWr = 1'b1; cyc(1); slpEnWr = 1'b0;
  endtask

  task automatic pulseResume();
    resumeEvt = 1'b1; cyc(1); resumeEvt = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      secTick = 1'b1; cyc(1); secTick = 1'b0; cyc(2);
    end
  endtask

  task automatic waitAsleep(logic v, string tag);
    int n = 0;
    while (asleep !== v && n < 100) begin cyc(1); n++; end
    check(tag, "reach asleep level", int'(asleep), int'(v));
  endtask

  initial begin
    int gap;
    cyc(3);
    // R1 reset state
    check("R1", "stpClkReq", int'(stpClkReq), 0);
    check("R1", "cacheSleep", int'(cacheSleep), 0);
    check("R1", "clkStop", int'(clkStop), 0);
    check("R1", "pwrOn", int'(pwrOn), 1);
    check("R1", "wakeSts", int'(wakeSts), 0);
    check("R1", "prevState", int'(prevState), 0);
    rstN = 1'b1; cyc(2);

    // R2 unsupported code is ignored
    reqSleep(3'd3); cyc(3);
    check("R2", "stpClkReq after code 3", int'(stpClkReq), 0);

    // R3 entry to suspend-to-RAM with a slow acknowledge; R4 strays during wait
    reqSleep(3'd5); cyc(2);
    reqSleep(3'd7);
    pulseResume();
    check("R4", "asleep after stray resume", int'(asleep), 0);
    cyc(4);
    check("R3", "stpClkReq waiting on ack", int'(stpClkReq), 1);
    stopGntAck = 1'b1; cyc(1); stopGntAck = 1'b0;
    waitAsleep(1'b1, "R3");

    // R6 resume and cache-sleep gap
    pulseResume();
    gap = 1;
    while (cacheSleep === 1'b1 && gap < 50) begin cyc(1); gap++; end
    check("R6", "cache sleep held >= 4 cycles", int'(gap >= 4), 1);
    waitAsleep(1'b0, "R6");
    cyc(STPCLK + 2);
    check("R5", "wakeSts after resume", int'(wakeSts), 1);
    check("R7", "prevState after STR", int'(prevState), 5);
    check("R4", "target kept despite stray strobe", int'(prevState), 5);
    wakeClr = 1'b1; cyc(1); wakeClr = 1'b0;
    check("R5", "wakeSts after clear", int'(wakeSts), 0);

    // R9 button hold during suspend-to-disk retargets to soft-off
    reqSleep(3'd6); stopGntAck = 1'b1; cyc(1); stopGntAck = 1'b0;
    waitAsleep(1'b1, "R3");
    pwrBtn = 1'b1; ticks(HOLD + 1); pwrBtn = 1'b0; cyc(2);
    check("R9", "still asleep after hold", int'(asleep), 1);
    pulseResume(); cyc(STEP + WAKE + STPCLK + 3);
    check("R9", "prevState after hold in STD", int'(prevState), 7);

    // R8 full reset skips the stop-clock handshake
    fullRstCmd = 1'b1; cyc(1); fullRstCmd = 1'b0;
    check("R8", "clkStop first", int'(clkStop), 1);
    check("R8", "stpClkReq stays low", int'(stpClkReq), 0);
    waitAsleep(1'b1, "R8");
    pulseResume(); cyc(STEP + WAKE + STPCLK + 3);
    check("R8", "prevState after full reset", int'(prevState), 7);

    // R10 short presses do not accumulate
    pwrBtn = 1'b1; ticks(HOLD - 1); pwrBtn = 1'b0; cyc(2);
    pwrBtn = 1'b1; ticks(HOLD - 1); pwrBtn = 1'b0; cyc(2);
    check("R10", "no override after split presses", int'(clkStop), 0);
    check("R10", "power kept", int'(pwrOn), 1);

    // R9 full hold in full-on forces soft-off
    pwrBtn = 1'b1; ticks(HOLD); pwrBtn = 1'b0;
    waitAsleep(1'b1, "R9");
    check("R9", "stpClkReq low in forced sleep", int'(stpClkReq), 0);
    // R9 hold in soft-off has no effect
    pwrBtn = 1'b1; ticks(HOLD + 1); pwrBtn = 1'b0; cyc(2);
    check("R9", "stays asleep in soft-off", int'(asleep), 1);
    pulseResume(); cyc(STEP + WAKE + STPCLK + 3);
    check("R9", "back to full-on", int'(pwrOn), 1);

    cyc(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule